// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

A purely combinational integer ALU for the execute stage of a small RISC core. It accepts two operands of `WIDTH` bits (32 by default) and a 4-bit operation code, and returns a result word together with a zero indication and a signed-overflow indication. One ripple-carry adder/subtractor is shared by addition, subtraction and both magnitude comparisons. Subtraction is formed by inverting the second operand and injecting a carry of one at bit 0.

Equality tests use the zero flag after a subtraction. Operand extension, shifting, multiplication, division and the exception handling that follows an overflow all sit outside this block. The overflow output is only a report, and the result is always produced.

Top module: `int_alu`

## Requirements
- R1: Code 0010 (add) and code 0011 (add, no overflow report) both return (a_i + b_i) mod 2^WIDTH.
- R2: Code 0110 (subtract) and code 1000 (subtract, no overflow report) both return (a_i - b_i) mod 2^WIDTH.
- R3: For code 0010, ovf_o is 1 exactly when both operands share a sign bit and the result's sign bit differs from it. For code 0110, ovf_o is 1 exactly when the operand sign bits differ and the result's sign bit differs from that of a_i.
- R4: For every code other than 0010 and 0110, ovf_o is 0. This covers both comparisons, the non-reporting arithmetic codes, the logic codes and the unused codes.
- R5: Code 0000 returns a_i AND b_i, code 0001 returns a_i OR b_i, code 0100 returns a_i XOR b_i, and code 0101 returns NOT(a_i OR b_i), all bit by bit.
- R6: Code 0111 returns 1 in bit 0 when a_i is less than b_i as two's-complement numbers, and 0 otherwise. All other result bits are 0. The answer is correct even when a_i - b_i overflows.
- R7: Code 1001 returns 1 in bit 0 when a_i is less than b_i as unsigned numbers, and 0 otherwise. All other result bits are 0.
- R8: zero_o is 1 exactly when every bit of result_o is 0.
- R9: Codes 1010 through 1111 return a result of all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (subtrahend for subtraction) |
| op_i | input | 4 | Operation code |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow, for codes 0010 and 0110 only |

## Verification
The checks assume that operands and operation code are stable when they are evaluated. The block holds no state, so no sequence of inputs is assumed. The bench changes inputs once per clock and checks them half a period later, which keeps every check away from values that are still settling. Every one of the sixteen codes is crossed with a set of boundary operands: zero, one, all ones, the most positive and most negative values and their neighbours, and alternating patterns. Random operand pairs are added on top of that set.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_ADDU = 4'b0011,
    OP_XOR  = 4'b0100,
    OP_NOR  = 4'b0101,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_SUBU = 4'b1000,
    OP_SLTU = 4'b1001
  } alu_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] b_x;

  assign carry[0] = sub_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign b_x[i]     = b_i[i] ^ sub_i;
    assign sum_o[i]   = a_i[i] ^ b_x[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_x[i]) | (a_i[i] & carry[i]) | (b_x[i] & carry[i]);
  end

  assign cout_o = carry[WIDTH];
  // carry into sign bit differs from carry out of it
  assign ovf_o  = carry[WIDTH] ^ carry[WIDTH-1];
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOR:  res_o = ~(a_i | b_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  alu_op_e          op;
  logic             sub;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             add_ovf;
  logic [WIDTH-1:0] logic_res;
  logic             lt_signed;
  logic             lt_unsigned;

  assign op  = alu_op_e'(op_i);
  assign sub = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);

  int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub),
    .sum_o (sum),
    .cout_o(cout),
    .ovf_o (add_ovf)
  );

  int_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op),
    .res_o(logic_res)
  );

  // true sign of the difference survives overflow
  assign lt_signed   = sum[WIDTH-1] ^ add_ovf;
  assign lt_unsigned = ~cout;

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_NOR: result_o = logic_res;
      OP_ADD, OP_SUB: begin
        result_o = sum;
        ovf_o    = add_ovf;
      end
      OP_ADDU, OP_SUBU: result_o = sum;
      OP_SLT:           result_o = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU:          result_o = {{(WIDTH-1){1'b0}}, lt_unsigned};
      default:          result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);
  always_comb begin
    if (op_i != OP_ADD && op_i != OP_SUB)
      assert_no_overflow_R4: assert (!ovf_o);
    if (op_i == OP_ADD && ovf_o)
      assert_add_ovf_signs_R3: assert (a_i[WIDTH-1] == b_i[WIDTH-1] && result_o[WIDTH-1] != a_i[WIDTH-1]);
    if (op_i == OP_SUB && a_i == b_i)
      assert_sub_equal_zero_R2: assert (zero_o && !ovf_o);
    if (op_i == OP_SLT || op_i == OP_SLTU)
      assert_cmp_upper_clear_R6: assert (result_o[WIDTH-1:1] == '0);
    if (op_i == OP_XOR && a_i == b_i)
      assert_xor_equal_zero_R8: assert (zero_o);
    if (op_i >= 4'b1010)
      assert_unused_zero_R9: assert (zero_o);
    if (op_i == OP_SLTU && a_i == b_i)
      assert_sltu_equal_R7: assert (!result_o[0]);
  end
endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .result_o(result_o),
  .zero_o  (zero_o),
  .ovf_o   (ovf_o)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [3:0]   op;
  logic [W-1:0] result;
  logic         zero, ovf;
  int           n_vec = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  int_alu #(.WIDTH(W)) u_dut (
    .a_i(a), .op_i(op), .b_i(b),
    .result_o(result), .zero_o(zero), .ovf_o(ovf)
  );

  logic [W-1:0] corners [12];

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_v, input logic [3:0] top);
    logic [W-1:0] exp_r;
    logic         exp_v;
    string        req;
    @(posedge clk);
    a = ta; b = tb_v; op = top;
    exp_v = 1'b0;
    case (top)
      4'b0000: begin exp_r = ta & tb_v;    req = "R5"; end
      4'b0001: begin exp_r = ta | tb_v;    req = "R5"; end
      4'b0100: begin exp_r = ta ^ tb_v;    req = "R5"; end
      4'b0101: begin exp_r = ~(ta | tb_v); req = "R5"; end
      4'b0010: begin
        exp_r = ta + tb_v; req = "R1";
        exp_v = (ta[W-1] == tb_v[W-1]) && (exp_r[W-1] != ta[W-1]);
      end
      4'b0011: begin exp_r = ta + tb_v; req = "R1"; end
      4'b0110: begin
        exp_r = ta - tb_v; req = "R2";
        exp_v = (ta[W-1] != tb_v[W-1]) && (exp_r[W-1] != ta[W-1]);
      end
      4'b1000: begin exp_r = ta - tb_v; req = "R2"; end
      4'b0111: begin exp_r = W'($signed(ta) < $signed(tb_v)); req = "R6"; end
      4'b1001: begin exp_r = W'(ta < tb_v); req = "R7"; end
      default: begin exp_r = '0; req = "R9"; end
    endcase
    @(negedge clk);
    n_vec++;
    if (result !== exp_r) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h", req, top, ta, tb_v, result, exp_r);
    end
    if (ovf !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h ovf actual=%b expected=%b",
               (top == 4'b0010 || top == 4'b0110) ? "R3" : "R4", top, ta, tb_v, ovf, exp_v);
    end
    if (zero !== (exp_r == '0)) begin
      n_fail++;
      $display("FAIL R8 op=%b a=%h b=%h zero actual=%b expected=%b", top, ta, tb_v, zero, exp_r == '0);
    end
  endtask

  initial begin
    corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFE,
                32'h8000_0001, 32'h2, 32'hFFFF_FFFE, 32'h5555_5555, 32'hAAAA_AAAA, 32'h0001_0000};
    a = '0; b = '0; op = '0;
    // idle state: AND of zeros
    apply('0, '0, 4'b0000);
    // targeted: R6 signed compare across overflowing subtraction
    apply(32'h8000_0000, 32'h0000_0001, 4'b0111);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
    // R3 both add directions, R4 suppressed variants
    apply(32'h7FFF_FFFF, 32'h1, 4'b0010);
    apply(32'h8000_0000, 32'h8000_0000, 4'b0010);
    apply(32'h7FFF_FFFF, 32'h1, 4'b0011);
    apply(32'h8000_0000, 32'h1, 4'b0110);
    apply(32'h8000_0000, 32'h1, 4'b1000);
    // R7 unsigned compare disagreeing with signed
    apply(32'h1, 32'hFFFF_FFFF, 4'b1001);
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          apply(corners[i], corners[j], 4'(o));
    for (int k = 0; k < 4000; k++)
      apply($urandom, $urandom, 4'($urandom_range(0, 15)));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule